// File: doc/BRIEF.md
# Time-Sliced Seven-Port Crossbar

This block is a non-blocking crossbar. Seven 10-bit input ports can be routed to seven 10-bit output ports under any mapping. Each output names its source with its own 3-bit select. The block does not build a separate wide multiplexer for every output. A core clock instead steps through seven slots per frame. In each slot a single shared 10-bit selector picks one input port. That word is pushed into a set of per-output shift lanes. When the last slot ends, each output register picks the lane position that holds its chosen source. All outputs then change together, and a one-cycle strobe marks the update.

The ports carry words at one seventh of the core clock rate. The driver holds every input port steady for a whole seven-cycle frame. It may change inputs and selects in the cycle that follows the strobe. Source selects are captured once, in the first slot of each frame. A select of 7 forces its output to zero.

Top module: `tdm_xbar`

## Requirements
- R1: In one frame every output may take any input port 0..6, including its own port number. Any number of outputs may take the same source at the same time.
- R2: Bit k of an output word equals bit k of the selected input word, for every k from 0 to 9. Inputs and outputs are packed word p at bits [10p+9:10p], and selects as select o at bits [3o+2:3o].
- R3: Output words change only on the clock edge that also raises the frame strobe. They hold their value for the other six cycles of each frame.
- R4: The frame strobe is high for exactly one core cycle in every seven. The output words first show the new frame's values in that same cycle.
- R5: A select value of 7 drives that output to all zeros for the frame. The other outputs are not affected.
- R6: A select is captured in slot 0 of a frame. A change made later in that frame does not affect that frame's output and takes effect from the next frame.
- R7: A synchronous active-high reset clears the slot counter, the lanes, the captured selects and the outputs. After reset is released, the outputs read zero and the strobe stays low until the seventh rising edge. That edge completes the first frame.
- R8: The slot counter counts 0 to 6 and wraps, and input port s is sampled in slot s. The output therefore returns the word that was present on the selected input during that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, seven cycles per port frame |
| rst | input | 1 | Synchronous active-high reset |
| in_flat | input | 70 | Seven packed input words, port p at bits [10p+9:10p] |
| sel_flat | input | 21 | Seven packed source selects, output o at bits [3o+2:3o] |
| out_flat | output | 70 | Seven packed output words, output o at bits [10o+9:10o] |
| frame_strobe | output | 1 | One-cycle pulse when the outputs take a new frame |

## Verification
The bench steps frame by frame and checks the strobe and all seven outputs at every cycle of each frame. A design whose lane tap is off by one position would return a neighbouring port's word, or the previous frame's word. Identity, reversed, rotated and broadcast mappings with distinct words per port expose this. Walking-bit and complement patterns would show any swapped or shifted bit inside a word. A select change made in slot 2 would leak into the current frame if selects were read continuously rather than captured in slot 0. A select of 7 mixed with valid selects would show whether the out-of-range value returns garbage or disturbs other outputs. After reset, any early update or strobe before the seventh edge shows up as a nonzero output or a misplaced pulse.

// File: rtl/tdm_xbar_pkg.sv
package tdm_xbar_pkg;

    parameter int XB_PORTS  = 7;
    parameter int XB_WORD_W = 10;
    parameter int XB_SEL_W  = 3;

    // Where an output lane finds its chosen word on the last slot
    typedef enum logic [1:0] {
        TAP_NONE,
        TAP_LIVE,
        TAP_STORED
    } tap_kind_e;

    // Shift position holding the word of source port src once the last
    // slot is reached; the last port itself is still on the live selector.
    function automatic int stored_pos(input int src, input int np);
        return np - 2 - src;
    endfunction

endpackage

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl #(
    parameter int NP = tdm_xbar_pkg::XB_PORTS,
    parameter int CW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] slot,
    output logic          frame_start,
    output logic          frame_last
);
    localparam logic [CW-1:0] LAST_SLOT = CW'(NP - 1);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (slot == LAST_SLOT)
            slot <= '0;
        else
            slot <= slot + 1'b1;
    end

    assign frame_start = (slot == '0);
    assign frame_last  = (slot == LAST_SLOT);

endmodule

// File: rtl/tdm_sampler.sv
module tdm_sampler #(
    parameter int NP = tdm_xbar_pkg::XB_PORTS,
    parameter int W  = tdm_xbar_pkg::XB_WORD_W,
    parameter int CW = $clog2(NP)
) (
    input  logic [NP*W-1:0] in_flat,
    input  logic [CW-1:0]   slot,
    output logic [W-1:0]    sample_word
);
    // One shared selector swept across the ports by the slot number
    always_comb begin
        sample_word = '0;
        for (int p = 0; p < NP; p++) begin
            if (slot == CW'(p))
                sample_word = in_flat[p*W +: W];
        end
    end

endmodule

// File: rtl/tdm_lane.sv
module tdm_lane
    import tdm_xbar_pkg::*;
#(
    parameter int NP = XB_PORTS,
    parameter int W  = XB_WORD_W,
    parameter int SW = XB_SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  sample_word,
    input  logic          frame_start,
    input  logic          frame_last,
    input  logic [SW-1:0] src_sel,
    output logic [W-1:0]  out_word,
    output logic [SW-1:0] src_q
);
    localparam int DEPTH = NP - 1;

    logic [W-1:0] shreg [DEPTH];
    logic [W-1:0] tap;
    tap_kind_e    kind;

    // Shift lane: position 0 holds the newest sampled word
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                shreg[i] <= '0;
        end else begin
            shreg[0] <= sample_word;
            for (int i = 1; i < DEPTH; i++)
                shreg[i] <= shreg[i-1];
        end
    end

    // Source select captured once per frame, in slot 0
    always_ff @(posedge clk) begin
        if (rst)
            src_q <= '0;
        else if (frame_start)
            src_q <= src_sel;
    end

    always_comb begin
        kind = TAP_NONE;
        tap  = '0;
        if (int'(src_q) == NP - 1) begin
            kind = TAP_LIVE;
            tap  = sample_word;
        end else begin
            for (int p = 0; p < NP - 1; p++) begin
                if (int'(src_q) == p) begin
                    kind = TAP_STORED;
                    tap  = shreg[stored_pos(p, NP)];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_word <= '0;
        else if (frame_last)
            out_word <= (kind == TAP_NONE) ? '0 : tap;
    end

endmodule

// File: rtl/tdm_xbar.sv
module tdm_xbar
    import tdm_xbar_pkg::*;
#(
    parameter int NUM_PORTS = XB_PORTS,
    parameter int WORD_W    = XB_WORD_W,
    parameter int SEL_W     = XB_SEL_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_PORTS*WORD_W-1:0] in_flat,
    input  logic [NUM_PORTS*SEL_W-1:0]  sel_flat,
    output logic [NUM_PORTS*WORD_W-1:0] out_flat,
    output logic                      frame_strobe
);
    localparam int CW = $clog2(NUM_PORTS);

    logic [CW-1:0]              slot_q;
    logic                       frame_start;
    logic                       frame_last;
    logic [WORD_W-1:0]          sample_word;
    logic [NUM_PORTS*SEL_W-1:0] src_lat_flat;

    tdm_slot_ctrl #(.NP(NUM_PORTS), .CW(CW)) u_slot (
        .clk         (clk),
        .rst         (rst),
        .slot        (slot_q),
        .frame_start (frame_start),
        .frame_last  (frame_last)
    );

    tdm_sampler #(.NP(NUM_PORTS), .W(WORD_W), .CW(CW)) u_sampler (
        .in_flat     (in_flat),
        .slot        (slot_q),
        .sample_word (sample_word)
    );

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_lane
        tdm_lane #(.NP(NUM_PORTS), .W(WORD_W), .SW(SEL_W)) u_lane (
            .clk         (clk),
            .rst         (rst),
            .sample_word (sample_word),
            .frame_start (frame_start),
            .frame_last  (frame_last),
            .src_sel     (sel_flat[o*SEL_W +: SEL_W]),
            .out_word    (out_flat[o*WORD_W +: WORD_W]),
            .src_q       (src_lat_flat[o*SEL_W +: SEL_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            frame_strobe <= 1'b0;
        else
            frame_strobe <= frame_last;
    end

endmodule

// File: rtl/tdm_xbar_checker.sv
module tdm_xbar_checker #(
    parameter int NP = 7,
    parameter int W  = 10,
    parameter int SW = 3,
    parameter int CW = 3
) (
    input logic           clk,
    input logic           rst,
    input logic [NP*W-1:0]  in_flat,
    input logic [NP*W-1:0]  out_flat,
    input logic           frame_strobe,
    input logic [CW-1:0]  slot,
    input logic [NP*SW-1:0] src_lat_flat
);

    for (genvar o = 0; o < NP; o++) begin : g_out
        logic [SW-1:0] s_o;
        logic [W-1:0]  w_o;
        assign s_o = src_lat_flat[o*SW +: SW];
        assign w_o = out_flat[o*W +: W];

        // R1 and R2: whole word, bit for bit, from the chosen port
        assert_route_R1: assert property (@(posedge clk) disable iff (rst)
            (frame_strobe && int'(s_o) < NP) |->
                (w_o == W'($past(in_flat) >> (int'(s_o) * W))));

        assert_null_sel_R5: assert property (@(posedge clk) disable iff (rst)
            (frame_strobe && int'(s_o) >= NP) |-> (w_o == '0));
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !frame_strobe |-> $stable(out_flat));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |=> !frame_strobe);

    assert_strobe_align_R4: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |-> (slot == '0));

    assert_sel_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (slot != CW'(1)) |-> $stable(src_lat_flat));

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_flat == '0 && !frame_strobe));

    assert_slot_range_R8: assert property (@(posedge clk) disable iff (rst)
        int'(slot) < NP);

endmodule

bind tdm_xbar tdm_xbar_checker #(
    .NP (NUM_PORTS),
    .W  (WORD_W),
    .SW (SEL_W),
    .CW (CW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_flat      (in_flat),
    .out_flat     (out_flat),
    .frame_strobe (frame_strobe),
    .slot         (slot_q),
    .src_lat_flat (src_lat_flat)
);

// File: tb/tdm_xbar_test.sv
`timescale 1ns/1ps
module tdm_xbar_test;
    localparam int NP = 7;
    localparam int W  = 10;
    localparam int SW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst;
    logic [NP*W-1:0]  in_flat;
    logic [NP*SW-1:0] sel_flat;
    logic [NP*W-1:0]  out_flat;
    logic            frame_strobe;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0]  drv_in   [NP];
    logic [SW-1:0] drv_sel  [NP];
    logic [SW-1:0] late_sel [NP];
    logic [W-1:0]  exp_now  [NP];
    logic [W-1:0]  exp_prev [NP];

    tdm_xbar uut (
        .clk          (clk),
        .rst          (rst),
        .in_flat      (in_flat),
        .sel_flat     (sel_flat),
        .out_flat     (out_flat),
        .frame_strobe (frame_strobe)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive();
        for (int p = 0; p < NP; p++) begin
            in_flat[p*W +: W]    = drv_in[p];
            sel_flat[p*SW +: SW] = drv_sel[p];
        end
    endtask

    task automatic compute_exp();
        for (int o = 0; o < NP; o++)
            exp_now[o] = (int'(drv_sel[o]) < NP) ? drv_in[drv_sel[o]] : '0;
    endtask

    // Starts at a negedge aligned just before slot 0; ends on the strobe negedge
    task automatic run_frame(input string tag, input string hold_tag, input bit mid);
        drive();
        compute_exp();
        for (int n = 1; n <= NP; n++) begin
            @(negedge clk);
            if (mid && n == 2) begin
                for (int o = 0; o < NP; o++) drv_sel[o] = late_sel[o];
                drive();
            end
            if (n < NP) begin
                check({"R4 strobe low mid-frame ", tag}, int'(frame_strobe), 0);
                for (int o = 0; o < NP; o++)
                    check({hold_tag, " hold ", tag}, int'(out_flat[o*W +: W]), int'(exp_prev[o]));
            end else begin
                check({"R4 strobe on seventh cycle ", tag}, int'(frame_strobe), 1);
                for (int o = 0; o < NP; o++)
                    check(tag, int'(out_flat[o*W +: W]), int'(exp_now[o]));
            end
        end
        for (int o = 0; o < NP; o++) exp_prev[o] = exp_now[o];
    endtask

    task automatic t_reset();
        rst = 1'b1;
        for (int p = 0; p < NP; p++) begin
            drv_in[p]  = W'(10'h155 + p * 37);
            drv_sel[p] = SW'(p);
            exp_prev[p] = '0;
        end
        drive();
        repeat (3) @(negedge clk);
        check("R7 strobe in reset", int'(frame_strobe), 0);
        check("R7 outputs in reset", int'(out_flat != '0), 0);
        rst = 1'b0;
        run_frame("R7 first frame after reset", "R7", 1'b0);
    endtask

    task automatic t_identity();
        for (int p = 0; p < NP; p++) begin
            drv_in[p]  = W'(10'h040 * (p + 1) + p);
            drv_sel[p] = SW'(p);
        end
        run_frame("R8 identity slot order", "R3", 1'b0);
    endtask

    task automatic t_broadcast();
        for (int p = 0; p < NP; p++) begin
            drv_in[p]  = W'(10'h300 - p * 11);
            drv_sel[p] = 3'd4;
        end
        run_frame("R1 broadcast port 4", "R3", 1'b0);
        for (int p = 0; p < NP; p++) drv_sel[p] = 3'd6;
        run_frame("R1 broadcast port 6", "R3", 1'b0);
        for (int p = 0; p < NP; p++) drv_sel[p] = 3'd0;
        run_frame("R1 broadcast port 0", "R3", 1'b0);
    endtask

    task automatic t_permute();
        for (int p = 0; p < NP; p++) begin
            drv_in[p]  = W'(10'h0A5 ^ (p * 73));
            drv_sel[p] = SW'(NP - 1 - p);
        end
        run_frame("R1 reversed map with self route", "R3", 1'b0);
        for (int p = 0; p < NP; p++) drv_sel[p] = SW'((p + 3) % NP);
        run_frame("R8 rotated map", "R3", 1'b0);
    endtask

    task automatic t_bits();
        for (int p = 0; p < NP; p++) begin
            drv_in[p]  = W'(1) << p;
            drv_sel[p] = SW'((p + 1) % NP);
        end
        run_frame("R2 walking one", "R3", 1'b0);
        for (int p = 0; p < NP; p++) drv_in[p] = ~(W'(1) << (p + 3));
        run_frame("R2 walking zero", "R3", 1'b0);
        for (int p = 0; p < NP; p++) drv_in[p] = (p % 2 == 0) ? 10'h2AA : 10'h155;
        run_frame("R2 alternating bits", "R3", 1'b0);
    endtask

    task automatic t_null();
        for (int p = 0; p < NP; p++) begin
            drv_in[p]  = W'(10'h3F0 + p);
            drv_sel[p] = (p % 2 == 0) ? 3'd7 : SW'(p - 1);
        end
        run_frame("R5 select seven gives zero", "R3", 1'b0);
    endtask

    task automatic t_midframe();
        for (int p = 0; p < NP; p++) begin
            drv_in[p]   = W'(10'h111 * (p % 3 + 1) + p);
            drv_sel[p]  = SW'(p);
            late_sel[p] = SW'(NP - 1 - p);
        end
        run_frame("R6 late select ignored this frame", "R3", 1'b1);
        run_frame("R6 late select used next frame", "R3", 1'b0);
    endtask

    initial begin
        rst = 1'b1;
        in_flat = '0;
        sel_flat = '0;
        t_reset();
        t_identity();
        t_broadcast();
        t_permute();
        t_bits();
        t_null();
        t_midframe();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL R4 watchdog actual=hung expected=completed run");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule